// File: doc/BRIEF.md
# SPI Master Interrupt Conditioner

This block merges two interrupt sources into the single CPU interrupt of an SPI master. The first source is an asynchronous line that arrives from an external device. The second is a "DMA data ready" event, which arrives as a one-cycle pulse from the DMA engine. Configuration inputs shape the external line: they set its active polarity, choose level or edge detection, and can bypass the conditioning altogether. A clear strobe from software services the interrupt. A readable clear flag stays set until the interrupt has really dropped.

An optional re-launch timer keeps a serviced interrupt from being lost while its source stays asserted. When software clears the interrupt and the external source is still active, the block counts a fixed number of system clocks. If the source has stayed active for that whole window, the block raises the interrupt again.

A second asynchronous input carries the external device's busy level. The block synchronizes it, exposes the level, and can use it to qualify returned data as valid.

Top module: `spim_irq_cond`

## Requirements
- R1: The external interrupt line and the busy input each pass through a `SYNC_STAGES`-flop synchronizer (default 2) before any detection. With level mode and active-high polarity, a rise on `extIrq` driven between two clock edges shows on `cpuIrq` after the second following edge, and not after the first.
- R2: `cfgActiveHigh`=1 treats a high synchronized line as the active state. `cfgActiveHigh`=0 treats a low line as active, and in edge mode a falling edge is then the event.
- R3: In level mode (`cfgEdgeMode`=0) the external contribution is high while the source is active and not yet serviced. A clear issued while the source is active masks the source. It stays masked until the source has gone inactive, which re-arms it.
- R4: In edge mode (`cfgEdgeMode`=1) a transition into the active state sets a sticky pending flag. The flag holds after the source goes inactive and drops only on a clear. If the source stays active after a clear, the interrupt stays low unless R8 applies.
- R5: With `cfgBypass`=1 the external contribution is the synchronized raw line. Polarity, detection type and clear have no effect on it.
- R6: A `dmaReady` pulse sets a sticky DMA flag that drives `cpuIrq` high from the next cycle on, and a clear drops the flag. If a new event and a clear fall in the same cycle, the event wins. The same rule applies to an edge event meeting a clear.
- R7: `clrPending` rises in the cycle after `clrWrite`. It returns to 0 after the first clock edge at which `cpuIrq` is low.
- R8: With `cfgRelaunchEn`=1, a clear taken while the source is active starts a window of `RELAUNCH_CYCLES` clocks. If the source stays active throughout, `cpuIrq` rises again exactly `RELAUNCH_CYCLES` edges after the clear edge, in both level and edge mode. If the source goes inactive first, the window is cancelled.
- R9: `busyLevel` is the synchronized busy input. `dataValid` is 1 when `busyQualEn`=0, and is otherwise the inverse of `busyLevel`.
- R10: During and right after reset, `cpuIrq`, `clrPending` and `busyLevel` are 0 and `dataValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extIrq | input | 1 | Asynchronous interrupt line from the external device |
| dmaReady | input | 1 | One-cycle DMA data-ready event |
| busyIn | input | 1 | Asynchronous busy level from the external device |
| cfgActiveHigh | input | 1 | 1: active high / rising edge; 0: active low / falling edge |
| cfgEdgeMode | input | 1 | 0: level detection; 1: edge detection |
| cfgBypass | input | 1 | 1: route the synchronized raw line to the output |
| cfgRelaunchEn | input | 1 | Enable the re-launch timer |
| busyQualEn | input | 1 | Enable busy qualification of returned data |
| clrWrite | input | 1 | One-cycle software clear strobe |
| cpuIrq | output | 1 | Combined CPU interrupt, also its status bit |
| clrPending | output | 1 | Clear flag; drops once the interrupt is low |
| busyLevel | output | 1 | Synchronized busy level |
| dataValid | output | 1 | Returned data may be used |

## Verification
A clear can land in the same cycle as a new DMA event, or as a fresh edge on the external line. In both cases the new event must survive the clear. The bench drives `clrWrite` and `dmaReady` on the same edge. It then expects `cpuIrq` to stay high and a second clear to be needed. A behavioural model compared on every clock also judges clears that meet an edge event or the last cycle of the re-launch window. Directed checks pin the exact cycle of the re-launch and the one-cycle life of `clrPending`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic clear;     // drop sticky pending flags
    logic relaunch;  // timer window expired with source still active
    logic served;    // level source masked after service
  } ctlStrobe_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else if (STAGES == 1) chain <= din[b];
      else chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[LAST];
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extIrq,
  input  logic       busyIn,
  input  logic       dmaReady,
  input  logic       cfgActiveHigh,
  input  logic       cfgEdgeMode,
  input  logic       cfgBypass,
  input  logic       busyQualEn,
  input  ctlStrobe_t strobe,
  output logic       srcActive,
  output logic       cpuIrq,
  output logic       busySync,
  output logic       dataValid
);
  logic extSync;
  logic prevActive;
  logic edgePend;
  logic dmaPend;
  logic edgeSeen;
  logic condReq;

  irqc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({busyIn, extIrq}),
    .dout ({busySync, extSync})
  );

  assign srcActive = cfgActiveHigh ? extSync : ~extSync;
  assign edgeSeen  = cfgEdgeMode & srcActive & ~prevActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      edgePend   <= 1'b0;
      dmaPend    <= 1'b0;
    end else begin
      prevActive <= srcActive;
      // new events take priority over a clear in the same cycle
      if (edgeSeen || (strobe.relaunch && cfgEdgeMode)) edgePend <= 1'b1;
      else if (strobe.clear)                            edgePend <= 1'b0;
      if (dmaReady)          dmaPend <= 1'b1;
      else if (strobe.clear) dmaPend <= 1'b0;
    end
  end

  assign condReq   = cfgEdgeMode ? edgePend : (srcActive & ~strobe.served);
  assign cpuIrq    = (cfgBypass ? extSync : condReq) | dmaPend;
  assign dataValid = ~(busyQualEn & busySync);

  AST_DMA_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    dmaReady |=> cpuIrq); // R6
  AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (dmaPend && !strobe.clear) |=> cpuIrq); // R6
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBypass && extSync) |-> cpuIrq); // R5
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEdgeMode && !cfgBypass && edgePend && !strobe.clear) |=> (edgePend || !cfgEdgeMode)); // R4
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int RELAUNCH_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clrWrite,
  input  logic       cfgRelaunchEn,
  input  logic       srcActive,
  input  logic       cpuIrq,
  output ctlStrobe_t strobe,
  output logic       clrPending
);
  localparam int TMR_W = $clog2(RELAUNCH_CYCLES + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(RELAUNCH_CYCLES);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(1);

  logic [TMR_W-1:0] relaunchTmr;
  logic             served;
  logic             expire;

  assign expire = cfgRelaunchEn & srcActive & (relaunchTmr == TMR_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relaunchTmr <= '0;
      served      <= 1'b0;
      clrPending  <= 1'b0;
    end else begin
      // masking of a level source after service
      if (!srcActive)    served <= 1'b0;
      else if (clrWrite) served <= 1'b1;
      else if (expire)   served <= 1'b0;
      // re-launch window
      if (!srcActive || !cfgRelaunchEn) relaunchTmr <= '0;
      else if (clrWrite)                relaunchTmr <= TMR_LOAD;
      else if (relaunchTmr != '0)       relaunchTmr <= relaunchTmr - TMR_LAST;
      // self-clearing clear flag
      if (clrWrite)     clrPending <= 1'b1;
      else if (!cpuIrq) clrPending <= 1'b0;
    end
  end

  always_comb begin
    strobe.clear    = clrWrite;
    strobe.relaunch = expire;
    strobe.served   = served;
  end

  AST_CLR_SET: assert property (@(posedge clk) disable iff (!rstN)
    clrWrite |=> clrPending); // R7
  AST_CLR_SELF: assert property (@(posedge clk) disable iff (!rstN)
    (clrPending && !cpuIrq && !clrWrite) |=> !clrPending); // R7
  AST_SERVED_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(served) |-> $past(clrWrite)); // R3
  AST_RELAUNCH_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> $past(srcActive)); // R8
endmodule

// File: rtl/spim_irq_cond.sv
module spim_irq_cond
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int RELAUNCH_CYCLES = 1024
) (
  input  logic clk,
  input  logic rstN,
  input  logic extIrq,
  input  logic dmaReady,
  input  logic busyIn,
  input  logic cfgActiveHigh,
  input  logic cfgEdgeMode,
  input  logic cfgBypass,
  input  logic cfgRelaunchEn,
  input  logic busyQualEn,
  input  logic clrWrite,
  output logic cpuIrq,
  output logic clrPending,
  output logic busyLevel,
  output logic dataValid
);
  ctlStrobe_t strobe;
  logic       srcActive;

  irqc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .extIrq        (extIrq),
    .busyIn        (busyIn),
    .dmaReady      (dmaReady),
    .cfgActiveHigh (cfgActiveHigh),
    .cfgEdgeMode   (cfgEdgeMode),
    .cfgBypass     (cfgBypass),
    .busyQualEn    (busyQualEn),
    .strobe        (strobe),
    .srcActive     (srcActive),
    .cpuIrq        (cpuIrq),
    .busySync      (busyLevel),
    .dataValid     (dataValid)
  );

  irqc_ctrl #(.RELAUNCH_CYCLES(RELAUNCH_CYCLES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .clrWrite      (clrWrite),
    .cfgRelaunchEn (cfgRelaunchEn),
    .srcActive     (srcActive),
    .cpuIrq        (cpuIrq),
    .strobe        (strobe),
    .clrPending    (clrPending)
  );

  AST_BUSY_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQualEn) |-> dataValid); // R9
endmodule

// File: tb/tb_spim_irq_cond.sv
`timescale 1ns/1ps
module tb_spim_irq_cond;
  localparam int RL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extIrq = 0, dmaReady = 0, busyIn = 0;
  logic cfgActiveHigh = 1, cfgEdgeMode = 0, cfgBypass = 0, cfgRelaunchEn = 0;
  logic busyQualEn = 0, clrWrite = 0;
  logic cpuIrq, clrPending, busyLevel, dataValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string curReq = "R10";

  always #4 clk = ~clk;

  spim_irq_cond #(.SYNC_STAGES(2), .RELAUNCH_CYCLES(RL)) dut (
    .clk(clk), .rstN(rstN), .extIrq(extIrq), .dmaReady(dmaReady), .busyIn(busyIn),
    .cfgActiveHigh(cfgActiveHigh), .cfgEdgeMode(cfgEdgeMode), .cfgBypass(cfgBypass),
    .cfgRelaunchEn(cfgRelaunchEn), .busyQualEn(busyQualEn), .clrWrite(clrWrite),
    .cpuIrq(cpuIrq), .clrPending(clrPending), .busyLevel(busyLevel), .dataValid(dataValid)
  );

  // ---------------- behavioural reference model ----------------
  logic lineQ[$];
  logic busyQ[$];
  bit   wasActive, edgeFlag, dmaFlag, masked, clrFlag;
  int   window;

  function automatic bit lineNow();
    return lineQ[1];
  endfunction

  function automatic bit expIrq();
    bit act = cfgActiveHigh ? lineNow() : !lineNow();
    bit ext;
    if (cfgBypass) ext = lineNow();
    else if (cfgEdgeMode) ext = edgeFlag;
    else ext = act && !masked;
    return ext || dmaFlag;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ = '{1'b0, 1'b0};
      busyQ = '{1'b0, 1'b0};
      wasActive = 0; edgeFlag = 0; dmaFlag = 0; masked = 0; clrFlag = 0; window = 0;
    end else begin
      bit act, fire, irqBefore;
      act = cfgActiveHigh ? lineNow() : !lineNow();
      irqBefore = expIrq();
      fire = cfgRelaunchEn && act && (window == 1);
      if ((cfgEdgeMode && act && !wasActive) || (fire && cfgEdgeMode)) edgeFlag = 1;
      else if (clrWrite) edgeFlag = 0;
      if (dmaReady) dmaFlag = 1;
      else if (clrWrite) dmaFlag = 0;
      if (!act) masked = 0;
      else if (clrWrite) masked = 1;
      else if (fire) masked = 0;
      if (!act || !cfgRelaunchEn) window = 0;
      else if (clrWrite) window = RL;
      else if (window > 0) window = window - 1;
      if (clrWrite) clrFlag = 1;
      else if (!irqBefore) clrFlag = 0;
      wasActive = act;
      void'(lineQ.pop_back()); lineQ.push_front(extIrq);
      void'(busyQ.pop_back()); busyQ.push_front(busyIn);
    end
  end

  task automatic cmp(string what, logic got, logic want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", curReq, what, got, want, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      cmp("model cpuIrq", cpuIrq, expIrq());
      cmp("model clrPending", clrPending, clrFlag);
      cmp("model busyLevel", busyLevel, busyQ[1]);
      cmp("model dataValid", dataValid, !(busyQualEn && busyQ[1]));
    end
  end

  task automatic chk(string req, string what, logic got, logic want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, got, want, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearOnce();
    clrWrite = 1; tick(1); clrWrite = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    tick(3);
    curReq = "R10";
    chk("R10", "reset cpuIrq", cpuIrq, 1'b0);
    chk("R10", "reset clrPending", clrPending, 1'b0);
    chk("R10", "reset busyLevel", busyLevel, 1'b0);
    chk("R10", "reset dataValid", dataValid, 1'b1);
    rstN = 1; tick(2);
    chk("R10", "post-reset cpuIrq", cpuIrq, 1'b0);

    // R1 / R3 synchronizer latency and level detection
    curReq = "R1";
    extIrq = 1; tick(1);
    chk("R1", "one edge after rise", cpuIrq, 1'b0);
    tick(1);
    chk("R1", "two edges after rise", cpuIrq, 1'b1);

    curReq = "R3";
    clearOnce();
    chk("R3", "level masked after clear", cpuIrq, 1'b0);
    chk("R7", "clrPending after write", clrPending, 1'b1);
    tick(1);
    chk("R7", "clrPending self-clears", clrPending, 1'b0);
    tick(10);
    chk("R3", "still masked while active", cpuIrq, 1'b0);
    extIrq = 0; tick(3); extIrq = 1; tick(2);
    chk("R3", "re-armed after inactive", cpuIrq, 1'b1);
    extIrq = 0; tick(2);
    chk("R3", "level follows source low", cpuIrq, 1'b0);

    // R2 polarity
    curReq = "R2";
    cfgActiveHigh = 0; tick(1);
    chk("R2", "low line active", cpuIrq, 1'b1);
    extIrq = 1; tick(2);
    chk("R2", "high line inactive", cpuIrq, 1'b0);
    cfgActiveHigh = 1; extIrq = 0; tick(2);
    chk("R2", "back to active high, line low", cpuIrq, 1'b0);

    // R4 edge mode
    curReq = "R4";
    cfgEdgeMode = 1; tick(1);
    extIrq = 1; tick(2);
    chk("R4", "edge not yet seen", cpuIrq, 1'b0);
    tick(1);
    chk("R4", "edge pending", cpuIrq, 1'b1);
    extIrq = 0; tick(4);
    chk("R4", "sticky after source low", cpuIrq, 1'b1);
    clearOnce();
    chk("R4", "cleared", cpuIrq, 1'b0);
    extIrq = 1; tick(3);
    chk("R4", "second edge", cpuIrq, 1'b1);
    clearOnce(); tick(20);
    chk("R4", "no relaunch when disabled", cpuIrq, 1'b0);
    extIrq = 0; tick(3);

    // R8 relaunch timer, edge mode
    curReq = "R8";
    cfgRelaunchEn = 1;
    extIrq = 1; tick(3);
    chk("R8", "edge pending before clear", cpuIrq, 1'b1);
    clearOnce();
    tick(RL - 1);
    chk("R8", "edge relaunch one cycle early", cpuIrq, 1'b0);
    tick(1);
    chk("R8", "edge relaunch on time", cpuIrq, 1'b1);
    clearOnce(); tick(3);
    extIrq = 0; tick(12);
    chk("R8", "window cancelled", cpuIrq, 1'b0);
    // level mode
    cfgEdgeMode = 0;
    extIrq = 1; tick(3);
    chk("R8", "level active", cpuIrq, 1'b1);
    clearOnce();
    chk("R8", "level cleared", cpuIrq, 1'b0);
    tick(RL - 1);
    chk("R8", "level relaunch one cycle early", cpuIrq, 1'b0);
    tick(1);
    chk("R8", "level relaunch on time", cpuIrq, 1'b1);
    clearOnce(); extIrq = 0; tick(3);
    cfgRelaunchEn = 0; tick(1);

    // R5 bypass
    curReq = "R5";
    cfgBypass = 1; cfgActiveHigh = 0;
    extIrq = 1; tick(2);
    chk("R5", "raw line ignores polarity", cpuIrq, 1'b1);
    clearOnce();
    chk("R5", "clear has no effect in bypass", cpuIrq, 1'b1);
    chk("R7", "clrPending held while irq high", clrPending, 1'b1);
    tick(3);
    chk("R7", "clrPending still held", clrPending, 1'b1);
    extIrq = 0; tick(2);
    chk("R5", "raw line low", cpuIrq, 1'b0);
    tick(1);
    chk("R7", "clrPending drops after irq low", clrPending, 1'b0);
    cfgBypass = 0; cfgActiveHigh = 1; tick(2);

    // R6 DMA event and same-cycle clear
    curReq = "R6";
    dmaReady = 1; tick(1); dmaReady = 0;
    chk("R6", "dma raises irq", cpuIrq, 1'b1);
    tick(5);
    chk("R6", "dma sticky", cpuIrq, 1'b1);
    clearOnce();
    chk("R6", "dma cleared", cpuIrq, 1'b0);
    dmaReady = 1; clrWrite = 1; tick(1); dmaReady = 0; clrWrite = 0;
    chk("R6", "event beats same-cycle clear", cpuIrq, 1'b1);
    clearOnce();
    chk("R6", "second clear drops", cpuIrq, 1'b0);
    tick(2);

    // R9 busy qualifier
    curReq = "R9";
    busyIn = 1; tick(1);
    chk("R9", "busy one edge", busyLevel, 1'b0);
    tick(1);
    chk("R9", "busy synced", busyLevel, 1'b1);
    chk("R9", "valid when qualifier off", dataValid, 1'b1);
    busyQualEn = 1; tick(1);
    chk("R9", "invalid while busy", dataValid, 1'b0);
    busyIn = 0; tick(2);
    chk("R9", "valid after busy low", dataValid, 1'b1);
    tick(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule